// File: doc/BRIEF.md
# Buffered Page Program Sequencer

This block writes a byte range of any start address and length into a paged serial flash. The device has an internal SRAM page buffer. The range is cut into chunks at page boundaries. A chunk that covers less than a whole page is merged with the page's existing contents. To do this, the block first has the device copy that page into its buffer. Each chunk is then sent in a single program-through-buffer frame, and the data bytes come from a host byte stream. The block polls the device status after every command until the device reports ready. When verification is enabled, it also runs a compare of the buffer against the page and checks the mismatch flag.

The block sits above a byte-wide serial shifter, which is not part of this design. Each byte the block offers on the transmit side is one serial byte. The `last` flag ends the frame, and the shifter releases the chip select after that byte. When a frame has finished, the shifter returns, with a one-cycle `spi_rx_valid` pulse, the byte it received during the final byte of that frame. The block waits for this pulse after every frame, so only one frame is ever outstanding.

When the sequencer finishes, it reports how many bytes were programmed and whether a compare failed.

Top module: `paged_prog_seq`

## Requirements
- R1: The range is split into chunks. The first chunk runs from the start offset to the end of its page, or covers the whole length if that is shorter. Each later chunk is a full page, or the remaining length if that is shorter. A chunk at page p with in-page offset o is programmed at device address (p << PAGE_SHIFT) + o, where p = start_addr / PAGE_SIZE. This address is sent as three bytes, most significant byte first.
- R2: Any chunk shorter than PAGE_SIZE is preceded by a copy frame. The copy frame has four bytes: 0x53, then the 3-byte page address (p << PAGE_SHIFT, in-page bits zero). `last` is set only on its fourth byte.
- R3: Each chunk is programmed with one frame: 0x82, the 3-byte address from R1, then the chunk's host bytes in arrival order. `last` is set only on the final data byte.
- R4: After every copy, program or compare frame, the block sends two-byte status frames (0xD7, 0x00, with `last` on the second byte). It repeats them until the returned status has bit 7 (ready) set.
- R5: When `verify_en` was high at start, each program's ready is followed by a compare frame: 0x60, then the 3-byte page address, with `last` on the fourth byte. Its status polling follows. A returned status with bit 6 set means the compare failed.
- R6: On a compare failure the block stops at once. No further frame is sent. It raises `done` with `err` = 1, and `bytes_written` does not include the failing chunk.
- R7: `bytes_written` grows by a chunk's length only after that chunk has completed. On success it ends equal to `length`.
- R8: `din_ready` is high only while the data bytes of a program frame are being sent and `spi_tx_ready` is high. At all other times, including while idle, the host stream is stalled.
- R9: A start with `length` = 0 sends no frame and finishes with `done`, `err` = 0 and `bytes_written` = 0.
- R10: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted start until `done`.
- R11: After reset the block is idle: `busy`, `done`, `err`, `spi_tx_valid`, `din_ready` and `bytes_written` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a write; taken only while idle |
| start_addr | input | HADDR_W | Linear byte address of the first byte |
| length | input | LEN_W | Number of bytes to write |
| verify_en | input | 1 | Run a buffer compare after each program |
| din_valid | input | 1 | Host data byte valid |
| din_data | input | 8 | Host data byte |
| din_ready | output | 1 | Host data byte accepted |
| spi_tx_valid | output | 1 | Byte offered to the shifter |
| spi_tx_data | output | 8 | Byte to shift out |
| spi_tx_last | output | 1 | Final byte of the current frame |
| spi_tx_ready | input | 1 | Shifter accepts the offered byte |
| spi_rx_valid | input | 1 | Frame finished; response byte valid |
| spi_rx_data | input | 8 | Byte received during the frame's final byte |
| busy | output | 1 | Write in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Compare failed; held until the next start |
| bytes_written | output | LEN_W | Bytes programmed so far |

## Verification
The bench builds the block with a page size of 6 bytes and a page shift of 3. This non-power-of-two page keeps the page index and the device address visibly apart. It also makes multi-page ranges cheap, so one run covers leading partial chunks, trailing partial chunks and full middle pages. The bench's device model varies the number of busy polls per test and can fail any chosen compare. This reaches the re-poll loop, the verify path and an abort in the middle of a range. Random stalls on the shifter and on the host stream exercise backpressure during the data bytes.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int DEV_W = 24;

    localparam logic [7:0] OP_BUF_LOAD = 8'h53;
    localparam logic [7:0] OP_PROG_BUF = 8'h82;
    localparam logic [7:0] OP_CMP_BUF  = 8'h60;
    localparam logic [7:0] OP_STATUS   = 8'hD7;
    localparam logic [7:0] FILL_BYTE   = 8'h00;

    typedef enum logic [1:0] {
        FK_LOAD,
        FK_PROG,
        FK_CMP,
        FK_STAT
    } frame_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PLAN,
        S_HDR,
        S_DATA,
        S_ENDW
    } state_e;

    function automatic logic [7:0] opcode_of(frame_e k);
        case (k)
            FK_LOAD: return OP_BUF_LOAD;
            FK_PROG: return OP_PROG_BUF;
            FK_CMP:  return OP_CMP_BUF;
            default: return OP_STATUS;
        endcase
    endfunction

    function automatic logic [1:0] hdr_final_idx(frame_e k);
        return (k == FK_STAT) ? 2'd1 : 2'd3;
    endfunction

    function automatic logic dev_ready(logic [7:0] s);
        return s[7];
    endfunction

    function automatic logic dev_mismatch(logic [7:0] s);
        return s[6];
    endfunction

endpackage

// File: rtl/pps_chunker.sv
module pps_chunker
    import pps_pkg::*;
#(
    parameter int PAGE_SIZE  = 264,
    parameter int PAGE_SHIFT = 9,
    parameter int HADDR_W    = 22,
    parameter int LEN_W      = 16,
    localparam int CHUNK_W   = $clog2(PAGE_SIZE + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [HADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]   length,
    input  logic               advance,
    output logic [CHUNK_W-1:0] chunk,
    output logic               partial,
    output logic               empty,
    output logic [DEV_W-1:0]   page_dev,
    output logic [DEV_W-1:0]   prog_dev,
    output logic [LEN_W-1:0]   written
);
    logic [HADDR_W-1:0] page_q;
    logic [CHUNK_W-1:0] off_q;
    logic [LEN_W-1:0]   rem_q;
    logic [LEN_W-1:0]   wr_q;
    logic [CHUNK_W-1:0] room;

    always_comb begin
        room     = CHUNK_W'(PAGE_SIZE) - off_q;
        chunk    = (rem_q < LEN_W'(room)) ? CHUNK_W'(rem_q) : room;
        partial  = (chunk != CHUNK_W'(PAGE_SIZE));
        empty    = (rem_q == '0);
        page_dev = DEV_W'(page_q) << PAGE_SHIFT;
        prog_dev = page_dev + DEV_W'(off_q);
        written  = wr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            off_q  <= '0;
            rem_q  <= '0;
            wr_q   <= '0;
        end else if (load) begin
            page_q <= HADDR_W'(start_addr / HADDR_W'(PAGE_SIZE));
            off_q  <= CHUNK_W'(start_addr % HADDR_W'(PAGE_SIZE));
            rem_q  <= length;
            wr_q   <= '0;
        end else if (advance) begin
            page_q <= page_q + 1'b1;
            off_q  <= '0;
            rem_q  <= rem_q - LEN_W'(chunk);
            wr_q   <= wr_q + LEN_W'(chunk);
        end
    end
endmodule

// File: rtl/pps_frame_bytes.sv
module pps_frame_bytes
    import pps_pkg::*;
(
    input  frame_e           kind,
    input  logic [1:0]       idx,
    input  logic [DEV_W-1:0] page_dev,
    input  logic [DEV_W-1:0] prog_dev,
    output logic [7:0]       byte_o
);
    logic [DEV_W-1:0] addr;

    always_comb begin
        addr = (kind == FK_PROG) ? prog_dev : page_dev;
        if (idx == 2'd0)
            byte_o = opcode_of(kind);
        else if (kind == FK_STAT)
            byte_o = FILL_BYTE;
        else begin
            case (idx)
                2'd1:    byte_o = addr[23:16];
                2'd2:    byte_o = addr[15:8];
                default: byte_o = addr[7:0];
            endcase
        end
    end
endmodule

// File: rtl/paged_prog_seq.sv
module paged_prog_seq
    import pps_pkg::*;
#(
    parameter int PAGE_SIZE  = 264,
    parameter int PAGE_SHIFT = 9,
    parameter int HADDR_W    = 22,
    parameter int LEN_W      = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [HADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]   length,
    input  logic               verify_en,
    input  logic               din_valid,
    input  logic [7:0]         din_data,
    output logic               din_ready,
    output logic               spi_tx_valid,
    output logic [7:0]         spi_tx_data,
    output logic               spi_tx_last,
    input  logic               spi_tx_ready,
    input  logic               spi_rx_valid,
    input  logic [7:0]         spi_rx_data,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [LEN_W-1:0]   bytes_written
);
    localparam int CHUNK_W = $clog2(PAGE_SIZE + 1);

    state_e             st;
    frame_e             fk;
    frame_e             cmd;
    logic [1:0]         idx;
    logic [CHUNK_W-1:0] dcnt;
    logic               verify_q;
    logic               done_q;
    logic               err_q;

    logic [CHUNK_W-1:0] chunk;
    logic               partial;
    logic               empty;
    logic [DEV_W-1:0]   page_dev;
    logic [DEV_W-1:0]   prog_dev;
    logic [7:0]         hdr_byte;
    logic               load;
    logic               advance;
    logic               stat_end;
    logic               hdr_final;
    logic               data_final;

    pps_chunker #(
        .PAGE_SIZE (PAGE_SIZE),
        .PAGE_SHIFT(PAGE_SHIFT),
        .HADDR_W   (HADDR_W),
        .LEN_W     (LEN_W)
    ) u_chunk (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .start_addr(start_addr),
        .length    (length),
        .advance   (advance),
        .chunk     (chunk),
        .partial   (partial),
        .empty     (empty),
        .page_dev  (page_dev),
        .prog_dev  (prog_dev),
        .written   (bytes_written)
    );

    pps_frame_bytes u_bytes (
        .kind    (fk),
        .idx     (idx),
        .page_dev(page_dev),
        .prog_dev(prog_dev),
        .byte_o  (hdr_byte)
    );

    always_comb begin
        load       = (st == S_IDLE) && start;
        stat_end   = (st == S_ENDW) && spi_rx_valid && (fk == FK_STAT)
                     && dev_ready(spi_rx_data);
        advance    = stat_end && (((cmd == FK_PROG) && !verify_q) ||
                     ((cmd == FK_CMP) && !dev_mismatch(spi_rx_data)));
        hdr_final  = (idx == hdr_final_idx(fk));
        data_final = (dcnt == chunk - 1'b1);
        spi_tx_valid = (st == S_HDR) || ((st == S_DATA) && din_valid);
        spi_tx_data  = (st == S_DATA) ? din_data : hdr_byte;
        spi_tx_last  = ((st == S_HDR) && (fk != FK_PROG) && hdr_final) ||
                       ((st == S_DATA) && data_final);
        din_ready    = (st == S_DATA) && spi_tx_ready;
        busy         = (st != S_IDLE);
        done         = done_q;
        err          = err_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            fk       <= FK_STAT;
            cmd      <= FK_PROG;
            idx      <= '0;
            dcnt     <= '0;
            verify_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    verify_q <= verify_en;
                    err_q    <= 1'b0;
                    st       <= S_PLAN;
                end
                S_PLAN: begin
                    idx <= '0;
                    if (empty) begin
                        done_q <= 1'b1;
                        st     <= S_IDLE;
                    end else begin
                        fk <= partial ? FK_LOAD : FK_PROG;
                        st <= S_HDR;
                    end
                end
                S_HDR: if (spi_tx_ready) begin
                    idx <= idx + 1'b1;
                    if (hdr_final) begin
                        dcnt <= '0;
                        st   <= (fk == FK_PROG) ? S_DATA : S_ENDW;
                    end
                end
                S_DATA: if (din_valid && spi_tx_ready) begin
                    dcnt <= dcnt + 1'b1;
                    if (data_final) st <= S_ENDW;
                end
                S_ENDW: if (spi_rx_valid) begin
                    idx <= '0;
                    if (fk != FK_STAT) begin
                        cmd <= fk;
                        fk  <= FK_STAT;
                        st  <= S_HDR;
                    end else if (!dev_ready(spi_rx_data)) begin
                        st <= S_HDR;
                    end else begin
                        case (cmd)
                            FK_LOAD: begin
                                fk <= FK_PROG;
                                st <= S_HDR;
                            end
                            FK_PROG: begin
                                if (verify_q) begin
                                    fk <= FK_CMP;
                                    st <= S_HDR;
                                end else st <= S_PLAN;
                            end
                            default: begin
                                if (dev_mismatch(spi_rx_data)) begin
                                    err_q  <= 1'b1;
                                    done_q <= 1'b1;
                                    st     <= S_IDLE;
                                end else st <= S_PLAN;
                            end
                        endcase
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [LEN_W-1:0] length,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic             din_ready,
    input logic             spi_tx_valid,
    input logic [LEN_W-1:0] bytes_written
);
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (rst) len_q <= '0;
        else if (start && !busy) len_q <= length;
    end

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!spi_tx_valid && !din_ready));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_after_start_r10: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
        busy |-> (bytes_written <= len_q));

    p_err_with_done_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> done);
endmodule

bind paged_prog_seq pps_checker #(.LEN_W(LEN_W)) u_pps_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .length       (length),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .din_ready    (din_ready),
    .spi_tx_valid (spi_tx_valid),
    .bytes_written(bytes_written)
);

// File: tb/paged_prog_seq_test.sv
module paged_prog_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int PS  = 6;
    localparam int SH  = 3;
    localparam int HAW = 12;
    localparam int LW  = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [HAW-1:0] start_addr = '0;
    logic [LW-1:0] length = '0;
    logic verify_en = 1'b0;
    logic din_valid = 1'b0;
    logic [7:0] din_data = '0;
    logic din_ready;
    logic spi_tx_valid, spi_tx_last;
    logic [7:0] spi_tx_data;
    logic spi_tx_ready = 1'b0;
    logic spi_rx_valid = 1'b0;
    logic [7:0] spi_rx_data = '0;
    logic busy, done, err;
    logic [LW-1:0] bytes_written;

    paged_prog_seq #(.PAGE_SIZE(PS), .PAGE_SHIFT(SH), .HADDR_W(HAW), .LEN_W(LW)) uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .length(length),
        .verify_en(verify_en), .din_valid(din_valid), .din_data(din_data),
        .din_ready(din_ready), .spi_tx_valid(spi_tx_valid), .spi_tx_data(spi_tx_data),
        .spi_tx_last(spi_tx_last), .spi_tx_ready(spi_tx_ready),
        .spi_rx_valid(spi_rx_valid), .spi_rx_data(spi_rx_data),
        .busy(busy), .done(done), .err(err), .bytes_written(bytes_written)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails = 0;

    // expected byte stream: data, last flag, kind (selects requirement tag)
    logic [7:0] exp_d[$];
    bit         exp_l[$];
    int         exp_k[$];
    logic [7:0] host_q[$];

    int busy_n = 1;
    int fail_cmp = -1;
    int exp_cnt;
    bit exp_err;

    // device model state
    int busy_left = 0;
    int cmp_seen = 0;
    bit mis_flag = 0;
    int frame_pos = 0;
    logic [7:0] cur_op = '0;
    int rx_cnt = 0;
    logic [7:0] rx_byte = '0;
    logic [15:0] lfsr = 16'hACE1;

    bit done_seen = 0;
    bit done_err;
    logic [LW-1:0] done_cnt;

    function automatic string tag_of(int k);
        case (k)
            0: return "R2";
            1: return "R1";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(bit ok, string tag, string what, int got, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, expv);
        end
    endtask

    task automatic push(logic [7:0] d, bit l, int k);
        exp_d.push_back(d);
        exp_l.push_back(l);
        exp_k.push_back(k);
    endtask

    task automatic push_polls();
        for (int i = 0; i <= busy_n; i++) begin
            push(8'hD7, 1'b0, 3);
            push(8'h00, 1'b1, 3);
        end
    endtask

    task automatic push_addr(int a, int k, bit last_on_low);
        push(8'((a >> 16) & 255), 1'b0, k);
        push(8'((a >> 8) & 255), 1'b0, k);
        push(8'(a & 255), last_on_low, k);
    endtask

    task automatic build(int addr, int len, bit ver, int seed);
        int page, off, rem, ch, cmpn, pa;
        page = addr / PS; off = addr % PS; rem = len; cmpn = 0;
        exp_cnt = 0; exp_err = 0;
        for (int k = 0; k < len; k++) host_q.push_back(8'((seed + k * 37) & 255));
        while (rem > 0) begin
            ch = (rem < PS - off) ? rem : PS - off;
            pa = page << SH;
            if (ch != PS) begin
                push(8'h53, 1'b0, 0);
                push_addr(pa, 0, 1'b1);
                push_polls();
            end
            push(8'h82, 1'b0, 2);
            push_addr(pa + off, 1, 1'b0);
            for (int k = 0; k < ch; k++)
                push(host_q[exp_cnt + k], (k == ch - 1), 2);
            push_polls();
            if (ver) begin
                push(8'h60, 1'b0, 4);
                push_addr(pa, 4, 1'b1);
                push_polls();
                if (cmpn == fail_cmp) begin
                    exp_err = 1;
                    break;
                end
                cmpn++;
            end
            exp_cnt += ch; rem -= ch; page++; off = 0;
        end
    endtask

    // single negedge process: drives device/host inputs, then compares
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        spi_rx_valid = 1'b0;
        if (rx_cnt > 0) begin
            rx_cnt--;
            if (rx_cnt == 0) begin
                spi_rx_valid = 1'b1;
                spi_rx_data  = rx_byte;
            end
        end
        spi_tx_ready = (lfsr[1:0] != 2'b00);
        din_valid = (host_q.size() > 0) && (lfsr[3:2] != 2'b00);
        din_data  = (host_q.size() > 0) ? host_q[0] : 8'h00;
        #1;
        if (!rst) begin
            // R8: host stream only moves during program data bytes
            chk(din_ready == (busy && exp_k.size() > 0 && exp_k[0] == 2 &&
                              exp_d[0] != 8'h82 && frame_pos >= 4 && spi_tx_ready),
                "R8", "din_ready", din_ready, 0);
            if (spi_tx_valid && spi_tx_ready) begin
                if (exp_d.size() == 0) begin
                    chk(1'b0, "R6", "unexpected frame byte", spi_tx_data, 0);
                end else begin
                    chk(spi_tx_data == exp_d[0] && spi_tx_last == exp_l[0],
                        tag_of(exp_k[0]), "tx byte/last",
                        {spi_tx_last, spi_tx_data}, {exp_l[0], exp_d[0]});
                    void'(exp_d.pop_front()); void'(exp_l.pop_front());
                    void'(exp_k.pop_front());
                end
                if (frame_pos == 0) cur_op = spi_tx_data;
                frame_pos++;
                if (spi_tx_last) begin
                    frame_pos = 0;
                    rx_cnt = 2;
                    if (cur_op == 8'hD7) begin
                        rx_byte = (busy_left > 0) ? 8'h00 : {1'b1, mis_flag, 6'h00};
                        if (busy_left > 0) busy_left--;
                    end else begin
                        rx_byte = 8'h00;
                        busy_left = busy_n;
                        if (cur_op == 8'h60) begin
                            mis_flag = (cmp_seen == fail_cmp);
                            cmp_seen++;
                        end else mis_flag = 0;
                    end
                end
            end
            if (din_valid && din_ready) void'(host_q.pop_front());
            if (done) begin
                done_seen = 1;
                done_err  = err;
                done_cnt  = bytes_written;
            end
        end
    end

    task automatic run(int addr, int len, bit ver, int bn, int fc, int seed);
        busy_n = bn; fail_cmp = fc; cmp_seen = 0;
        build(addr, len, ver, seed);
        done_seen = 0;
        @(negedge clk);
        start = 1'b1; start_addr = HAW'(addr); length = LW'(len); verify_en = ver;
        @(negedge clk);
        start = 1'b0;
        #2;
        chk(busy == 1'b1, "R10", "busy after start", busy, 1);
        for (int t = 0; t < 20000 && !done_seen; t++) @(negedge clk);
        #2;
        chk(done_seen, "R10", "done seen", done_seen, 1);
        chk(done_err == exp_err, "R6", "err at done", done_err, exp_err);
        chk(int'(done_cnt) == exp_cnt, exp_err ? "R6" : "R7", "bytes_written",
            done_cnt, exp_cnt);
        chk(exp_d.size() == 0, "R1", "frames left unsent", exp_d.size(), 0);
        @(negedge clk); #2;
        chk(done == 1'b0 && busy == 1'b0, "R10", "done single pulse", done, 0);
        exp_d.delete(); exp_l.delete(); exp_k.delete(); host_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        // R11: reset state
        chk(!busy && !done && !err && !spi_tx_valid && !din_ready && bytes_written == 0,
            "R11", "reset state", {busy, done, err, spi_tx_valid, din_ready}, 0);
        run(0, 6, 0, 1, -1, 8'h10);      // R3 full page, no copy
        run(4, 10, 0, 2, -1, 8'h21);     // R1 R2 leading and trailing partial
        run(13, 3, 1, 0, -1, 8'h33);     // R5 verify pass, no busy polls
        run(7, 14, 1, 1, 1, 8'h47);      // R6 mismatch on second compare
        run(0, 0, 1, 1, -1, 8'h00);      // R9 zero length
        run(30, 1, 1, 3, -1, 8'h5A);     // R4 repeated busy polls, 1 byte
        run(11, 19, 1, 1, 0, 8'h66);     // R6 mismatch on first compare
        run(2, 25, 0, 1, -1, 8'h71);     // R1 R7 long multi-page
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule